// File: doc/BRIEF.md
# Reset Cause Status Register

This block is a single 16-bit status word on a simple synchronous register bus. It records which kind of event brought about the most recent system reset. Four one-cycle pulse inputs report the possible causes: power-on, the active-low external reset pin, a watchdog timeout and a software-commanded reset. Each cause has its own sticky flag. An event sets its own flag. It also clears those flags that this kind of reset is defined to wipe.

Boot firmware reads the word to decide how to recover. It then clears, or deliberately plants, flags through a bus write. The write polarity is inverted: a 0 in a flag's bit position sets that flag and a 1 clears it. The system reset input does not clear the flags. It only blocks bus writes while it is asserted. Cause events are accepted at all times.

Top module: `rst_cause_reg`

## Requirements
- R1: When `busAddr` equals `REG_ADDR`, `busRdData` shows the flags at these positions: bit 2 is power-on, bit 3 is external pin, bit 4 is watchdog and bit 5 is software reset. After a lone power-on pulse the word reads 0x0004.
- R2: Bits 15..6 and 1..0 of the word always read 0, whatever value was written to them.
- R3: When `busAddr` differs from `REG_ADDR`, `busRdData` is 0 and a write leaves the flags unchanged.
- R4: A write with `busWe`=1 to `REG_ADDR` and no cause pulse in that cycle sets each flag whose bit in `busWrData` is 0 and clears each flag whose bit is 1. The new value is visible after the next rising clock edge.
- R5: A power-on pulse sets the power-on flag and clears the other three flags.
- R6: An external pulse sets the external flag, clears the software and power-on flags, and leaves the watchdog flag unchanged.
- R7: A watchdog pulse sets the watchdog flag, clears the software and power-on flags, and leaves the external flag unchanged.
- R8: A software pulse sets the software flag, clears the power-on flag, and leaves the watchdog and external flags unchanged.
- R9: When several pulses arrive in one cycle, only the highest-ranked one acts. The ranking is power-on, then external, then watchdog, then software.
- R10: A cause pulse in the same cycle as a register write wins, and the write is discarded for all four flags.
- R11: While `sysRstN` is low, the flags keep their values and bus writes are ignored. Cause pulses are still applied.
- R12: In a cycle with no pulse and no accepted write, the flags hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sysRstN | input | 1 | Active-low system reset; blocks writes and does not clear the flags |
| porPulse | input | 1 | One-cycle power-on reset indication |
| extPulse | input | 1 | One-cycle external pin reset indication |
| wdogPulse | input | 1 | One-cycle watchdog reset indication |
| swPulse | input | 1 | One-cycle software reset indication |
| busAddr | input | ADDR_W | Register address |
| busWe | input | 1 | Write enable |
| busWrData | input | 16 | Write data, with inverted polarity per flag |
| busRdData | output | 16 | Combinational read data |

## Verification
Two pairs of functions can fall in the same cycle: two or more cause pulses together, and a cause pulse together with an accepted bus write. The bench provokes both pairs by driving the inputs in one cycle. It starts from flag patterns where the losing action would leave a visible trace, such as a write of 0x0000 that would set every flag. The result is judged by reading the word on the following cycle. It must match the winning event alone.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

  localparam int REG_W     = 16;
  localparam int NUM_CAUSE = 4;
  localparam int FLAG_LSB  = 2;

  // cause / flag indices; a lower index ranks higher
  localparam int C_POR  = 0;
  localparam int C_EXT  = 1;
  localparam int C_WDOG = 2;
  localparam int C_SW   = 3;

  typedef enum logic [1:0] {
    ACT_KEEP,
    ACT_SET,
    ACT_CLR
  } flagAct_e;

  typedef struct packed {
    logic [NUM_CAUSE-1:0] evtWin;   // at most one winning cause
    logic                 doWrite;  // accepted bus write
    logic                 readSel;  // address matches the register
  } strobe_t;

  // effect of a winning cause on one flag
  function automatic flagAct_e causeEffect(input int cause, input int flag);
    flagAct_e act;
    if (cause == flag) begin
      act = ACT_SET;
    end else begin
      unique case (cause)
        C_POR:          act = ACT_CLR;
        C_EXT, C_WDOG:  act = (flag == C_SW || flag == C_POR) ? ACT_CLR : ACT_KEEP;
        default:        act = (flag == C_POR) ? ACT_CLR : ACT_KEEP;
      endcase
    end
    return act;
  endfunction

endpackage

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rst_cause_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 2
) (
  input  logic                 clk,
  input  logic                 sysRstN,
  input  logic [NUM_CAUSE-1:0] causePulse,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  output strobe_t              strb
);

  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

  logic [NUM_CAUSE-1:0] winner;
  logic                 anyCause;
  logic                 addrHit;

  // scan from lowest rank upward so the highest-ranked cause overwrites
  always_comb begin
    winner = '0;
    for (int c = NUM_CAUSE - 1; c >= 0; c--) begin
      if (causePulse[c]) begin
        winner    = '0;
        winner[c] = 1'b1;
      end
    end
  end

  assign anyCause = |causePulse;
  assign addrHit  = (busAddr == MY_ADDR);

  always_comb begin
    strb.evtWin  = winner;
    strb.readSel = addrHit;
    strb.doWrite = busWe && addrHit && sysRstN && !anyCause;
  end

  // R9: a single winner per cycle
  a_r9_single_winner: assert property (@(posedge clk) disable iff (!sysRstN)
    $onehot0(strb.evtWin));

  // R9: power-on always wins when present
  a_r9_por_ranks_first: assert property (@(posedge clk) disable iff (!sysRstN)
    causePulse[C_POR] |-> strb.evtWin[C_POR]);

  // R9: external beats watchdog and software
  a_r9_ext_over_lower: assert property (@(posedge clk) disable iff (!sysRstN)
    (causePulse[C_EXT] && !causePulse[C_POR]) |-> strb.evtWin[C_EXT]);

  // R10: no write is accepted alongside any cause pulse
  a_r10_cause_blocks_write: assert property (@(posedge clk) disable iff (!sysRstN)
    (|causePulse) |-> !strb.doWrite);

endmodule

// File: rtl/rst_cause_dp.sv
module rst_cause_dp
  import rst_cause_pkg::*;
(
  input  logic             clk,
  input  logic             sysRstN,
  input  strobe_t          strb,
  input  logic [REG_W-1:0] busWrData,
  output logic [REG_W-1:0] busRdData
);

  localparam logic [REG_W-1:0] FLAG_MASK = REG_W'(((1 << NUM_CAUSE) - 1) << FLAG_LSB);

  logic [NUM_CAUSE-1:0] flagQ;
  logic [NUM_CAUSE-1:0] flagD;
  logic [REG_W-1:0]     rdWord;
  logic                 unusedWrBits;

  assign unusedWrBits = ^(busWrData & ~FLAG_MASK);

  always_comb begin
    flagD = flagQ;
    for (int f = 0; f < NUM_CAUSE; f++) begin
      if (|strb.evtWin) begin
        for (int c = 0; c < NUM_CAUSE; c++) begin
          if (strb.evtWin[c]) begin
            unique case (causeEffect(c, f))
              ACT_SET: flagD[f] = 1'b1;
              ACT_CLR: flagD[f] = 1'b0;
              default: flagD[f] = flagQ[f];
            endcase
          end
        end
      end else if (strb.doWrite) begin
        flagD[f] = ~busWrData[FLAG_LSB + f];
      end
    end
  end

  // storage deliberately untouched by the system reset
  always_ff @(posedge clk) begin
    flagQ <= flagD;
  end

  always_comb begin
    rdWord = '0;
    for (int f = 0; f < NUM_CAUSE; f++) begin
      rdWord[FLAG_LSB + f] = flagQ[f];
    end
    busRdData = strb.readSel ? rdWord : '0;
  end

  // R5: power-on leaves only its own flag
  a_r5_por_only: assert property (@(posedge clk) disable iff (!sysRstN)
    strb.evtWin[C_POR] |=> (flagQ == 4'b0001));

  // R6: external sets its flag, keeps watchdog
  a_r6_ext_effect: assert property (@(posedge clk) disable iff (!sysRstN)
    strb.evtWin[C_EXT] |=> (flagQ[C_EXT] && !flagQ[C_SW] && !flagQ[C_POR]
                            && flagQ[C_WDOG] == $past(flagQ[C_WDOG])));

  // R7: watchdog sets its flag, keeps external
  a_r7_wdog_effect: assert property (@(posedge clk) disable iff (!sysRstN)
    strb.evtWin[C_WDOG] |=> (flagQ[C_WDOG] && !flagQ[C_SW] && !flagQ[C_POR]
                             && flagQ[C_EXT] == $past(flagQ[C_EXT])));

  // R8: software sets its flag, keeps watchdog and external
  a_r8_sw_effect: assert property (@(posedge clk) disable iff (!sysRstN)
    strb.evtWin[C_SW] |=> (flagQ[C_SW] && !flagQ[C_POR]
                           && flagQ[C_EXT] == $past(flagQ[C_EXT])
                           && flagQ[C_WDOG] == $past(flagQ[C_WDOG])));

  // R4: accepted write stores the inverted data bits
  a_r4_inverted_write: assert property (@(posedge clk) disable iff (!sysRstN)
    strb.doWrite |=> (flagQ == ~{$past(busWrData[5]), $past(busWrData[4]),
                                 $past(busWrData[3]), $past(busWrData[2])}));

  // R12: idle cycles hold the flags
  a_r12_hold: assert property (@(posedge clk) disable iff (!sysRstN)
    (!(|strb.evtWin) && !strb.doWrite) |=> $stable(flagQ));

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_cause_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 2
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  logic              porPulse,
  input  logic              extPulse,
  input  logic              wdogPulse,
  input  logic              swPulse,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [15:0]       busWrData,
  output logic [15:0]       busRdData
);

  logic [NUM_CAUSE-1:0] causePulse;
  strobe_t              strb;

  always_comb begin
    causePulse         = '0;
    causePulse[C_POR]  = porPulse;
    causePulse[C_EXT]  = extPulse;
    causePulse[C_WDOG] = wdogPulse;
    causePulse[C_SW]   = swPulse;
  end

  rst_cause_ctrl #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
  ) u_ctrl (
    .clk        (clk),
    .sysRstN    (sysRstN),
    .causePulse (causePulse),
    .busAddr    (busAddr),
    .busWe      (busWe),
    .strb       (strb)
  );

  rst_cause_dp u_dp (
    .clk       (clk),
    .sysRstN   (sysRstN),
    .strb      (strb),
    .busWrData (busWrData),
    .busRdData (busRdData)
  );

endmodule

// File: tb/rst_cause_reg_bench.sv
module rst_cause_reg_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int REG_ADDR   = 2;
  localparam logic [ADDR_W-1:0] RA    = ADDR_W'(REG_ADDR);
  localparam logic [ADDR_W-1:0] OTHER = ADDR_W'(REG_ADDR + 5);

  logic              clk = 1'b0;
  logic              sysRstN = 1'b0;
  logic              porPulse = 1'b0, extPulse = 1'b0, wdogPulse = 1'b0, swPulse = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWe = 1'b0;
  logic [15:0]       busWrData = '0;
  logic [15:0]       busRdData;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t queueExp[$];
  event  readEv;
  int    vectors = 0;
  int    miscompares = 0;
  logic  finished = 1'b0;

  // model flags, index order: por, ext, wdog, sw
  logic [3:0] mdl = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rst_cause_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_rst_cause_reg (
    .clk, .sysRstN, .porPulse, .extPulse, .wdogPulse, .swPulse,
    .busAddr, .busWe, .busWrData, .busRdData
  );

  function automatic logic [15:0] mdlWord();
    return {10'b0, mdl[3], mdl[2], mdl[1], mdl[0], 2'b00};
  endfunction

  // one clock of stimulus; model follows the requirements
  task automatic cycle(input logic p, input logic e, input logic w, input logic s,
                       input logic we, input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    porPulse = p; extPulse = e; wdogPulse = w; swPulse = s;
    busWe = we; busAddr = a; busWrData = d;
    if (p)      mdl = 4'b0001;
    else if (e) mdl = {1'b0, mdl[2], 1'b1, 1'b0};
    else if (w) mdl = {1'b0, 1'b1, mdl[1], 1'b0};
    else if (s) mdl = {1'b1, mdl[2], mdl[1], 1'b0};
    else if (we && a == RA && sysRstN) mdl = ~{d[5], d[4], d[3], d[2]};
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    cycle(0, 0, 0, 0, 1, a, d);
  endtask

  task automatic check(input logic [ADDR_W-1:0] a, input string tag);
    item_t it;
    @(negedge clk);
    porPulse = 0; extPulse = 0; wdogPulse = 0; swPulse = 0;
    busWe = 0; busAddr = a; busWrData = 16'h0000;
    it.exp = (a == RA) ? mdlWord() : 16'h0000;
    it.tag = tag;
    queueExp.push_back(it);
    #1;
    -> readEv;
  endtask

  // monitor: pops expected items and compares with the read port
  initial begin
    forever begin
      @(readEv);
      if (queueExp.size() != 0) begin
        item_t it;
        it = queueExp.pop_front();
        vectors++;
        if (busRdData !== it.exp) begin
          miscompares++;
          $display("FAIL %s: read %h expected %h", it.tag, busRdData, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run hung, got no end expected end");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    cycle(1, 0, 0, 0, 0, RA, 16'h0);              // R5 power-on during reset
    @(negedge clk); sysRstN = 1'b1;
    check(RA, "R1 reset state / R5 power-on");
    check(OTHER, "R3 other address reads zero");

    wr(RA, 16'h0000);   check(RA, "R4 write zeros sets all");
    wr(RA, 16'hFFFF);   check(RA, "R4 write ones clears all");
    wr(RA, 16'hFFC3);   check(RA, "R2 reserved read zero");
    wr(OTHER, 16'hFFFF); check(RA, "R3 write elsewhere ignored");
    check(RA, "R12 idle hold");

    cycle(0, 1, 0, 0, 0, RA, 16'h0); check(RA, "R6 external event");
    wr(RA, 16'hFFEF);   check(RA, "R4 plant watchdog only");
    cycle(0, 0, 0, 1, 0, RA, 16'h0); check(RA, "R8 software event");
    wr(RA, 16'hFFC7);   check(RA, "R4 plant sw wd ext");
    cycle(0, 0, 1, 0, 0, RA, 16'h0); check(RA, "R7 watchdog event");

    wr(RA, 16'hFFFF);
    cycle(0, 1, 1, 1, 0, RA, 16'h0); check(RA, "R9 external beats lower");
    wr(RA, 16'hFFFF);
    cycle(0, 0, 1, 1, 0, RA, 16'h0); check(RA, "R9 watchdog beats software");
    cycle(1, 1, 1, 1, 0, RA, 16'h0); check(RA, "R9 power-on beats all");

    wr(RA, 16'hFFFF);
    cycle(0, 0, 0, 1, 1, RA, 16'h0000); check(RA, "R10 cause overrides write");

    @(negedge clk); sysRstN = 1'b0;
    check(RA, "R11 flags kept in reset");
    wr(RA, 16'h0000);   check(RA, "R11 write ignored in reset");
    cycle(0, 1, 0, 0, 0, RA, 16'h0); check(RA, "R11 cause applied in reset");
    @(negedge clk); sysRstN = 1'b1;
    check(RA, "R12 hold after reset release");

    @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule